// File: doc/BRIEF.md
# Banked Stack Pointer and Processor Mode Controller

This block keeps the processor's two stack pointers, main and process, along with the state that decides which one is in use. That state is the execution mode (Thread or Handler), a two-bit control word, a one-bit interrupt mask and the number of the exception being serviced. The core around it sends several kinds of request: exception entry and return, writes to special registers, interrupt enable and disable, and stack adjustments that give a register count. The block reports the active stack pointer, the current privilege level and whether configurable-priority exceptions are masked.

The core supplies the exception number on entry, and a supervisor call arrives as exception 11. Push and pop requests act on whichever stack pointer is active at that clock edge, so the same instruction stream runs on either stack. Special registers can be read back combinationally through the same select code that is used for writes.

Top module: `stack_mode_ctrl`

## Requirements
- R1: After reset the block is in Thread mode. Both stack pointers, the control word, the mask bit and the exception number are zero, and the main stack pointer is active.
- R2: In Handler mode `sp_active` is the main stack pointer whatever control bit 1 holds.
- R3: In Thread mode control bit 1 picks the stack pointer: 0 selects main and 1 selects process.
- R4: `privileged` is 1 in Handler mode and otherwise equals the inverse of control bit 0. A control write made while Thread mode is unprivileged leaves the control word unchanged.
- R5: `irq_disable` sets the mask bit and `irq_enable` clears it. When both are raised, disable wins. A special-register write to the mask wins over both. `irq_masked` reflects the bit.
- R6: `exc_enter` moves the block to Handler mode and captures `exc_num` into `exc_id`. Otherwise `exc_return` moves it to Thread mode and clears `exc_id` to zero.
- R7: `stk_push` lowers the active stack pointer by 4×`stk_count`. `stk_pop` raises it by the same amount, with modulo-2^32 wrap. Push wins over pop, and the inactive pointer is untouched. If a special-register write targets the active pointer in the same cycle, the write wins.
- R8: Stack pointer writes store bits [1:0] as zero, so both pointers are always word aligned.
- R9: Select codes are 0 for the main pointer, 1 for the process pointer, 2 for the control word (bit 0 privilege, bit 1 stack select) and 3 for the mask (bit 0). `sreg_rdata` returns the selected register, zero-extended, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_enter | input | 1 | Exception entry event |
| exc_num | input | EXC_W | Number of the exception being entered |
| exc_return | input | 1 | Exception processing completed |
| sreg_we | input | 1 | Special-register write strobe |
| sreg_sel | input | 2 | Special-register select code |
| sreg_wdata | input | DW | Special-register write data |
| sreg_rdata | output | DW | Selected special register, read combinationally |
| irq_disable | input | 1 | Set the interrupt mask |
| irq_enable | input | 1 | Clear the interrupt mask |
| stk_push | input | 1 | Lower the active stack pointer |
| stk_pop | input | 1 | Raise the active stack pointer |
| stk_count | input | CNT_W | Number of registers moved |
| sp_active | output | DW | Active stack pointer value |
| privileged | output | 1 | Current privilege level (1 = privileged) |
| irq_masked | output | 1 | Configurable-priority exceptions blocked |
| handler_mode | output | 1 | 1 in Handler mode, 0 in Thread mode |
| exc_id | output | EXC_W | Number of the exception being serviced |

## Verification
Each stack-adjust property assumes that no exception event and no special-register write arrives in the same cycle, because either of those can legally replace the arithmetic result. Each mask property excludes a concurrent write to the mask. The random stimulus lets all requests overlap freely, so the bench reference model decides every collision by the stated priorities. Directed steps then drive single requests, where the properties apply.

// File: rtl/stack_mode_ctrl.sv
module stack_mode_ctrl #(
  parameter int DW    = 32,
  parameter int CNT_W = 4,
  parameter int EXC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_enter,
  input  logic [EXC_W-1:0] exc_num,
  input  logic             exc_return,
  input  logic             sreg_we,
  input  logic [1:0]       sreg_sel,
  input  logic [DW-1:0]    sreg_wdata,
  output logic [DW-1:0]    sreg_rdata,
  input  logic             irq_disable,
  input  logic             irq_enable,
  input  logic             stk_push,
  input  logic             stk_pop,
  input  logic [CNT_W-1:0] stk_count,
  output logic [DW-1:0]    sp_active,
  output logic             privileged,
  output logic             irq_masked,
  output logic             handler_mode,
  output logic [EXC_W-1:0] exc_id
);
  localparam logic [1:0] SEL_MAIN = 2'd0;
  localparam logic [1:0] SEL_PROC = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;
  localparam int PADW = DW - CNT_W - 2;

  logic [DW-1:0]    main_sp, proc_sp;
  logic [1:0]       ctrl;
  logic             mask_bit, in_handler;
  logic [EXC_W-1:0] exc_q;

  wire use_proc = !in_handler && ctrl[1];
  wire priv     = in_handler || !ctrl[0];
  wire adjust   = stk_push || stk_pop;
  wire [DW-1:0] cur_sp  = use_proc ? proc_sp : main_sp;
  wire [DW-1:0] delta   = {{PADW{1'b0}}, stk_count, 2'b00};
  wire [DW-1:0] adj_sp  = stk_push ? cur_sp - delta : cur_sp + delta;
  wire [DW-1:0] wr_sp   = {sreg_wdata[DW-1:2], 2'b00};
  wire wr_main = sreg_we && sreg_sel == SEL_MAIN;
  wire wr_proc = sreg_we && sreg_sel == SEL_PROC;
  wire wr_ctrl = sreg_we && sreg_sel == SEL_CTRL;
  wire wr_mask = sreg_we && sreg_sel == SEL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_sp <= '0;
      proc_sp <= '0;
    end else begin
      if (wr_main)                  main_sp <= wr_sp;
      else if (adjust && !use_proc) main_sp <= adj_sp;
      if (wr_proc)                  proc_sp <= wr_sp;
      else if (adjust && use_proc)  proc_sp <= adj_sp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= 2'b00;
      mask_bit   <= 1'b0;
      in_handler <= 1'b0;
      exc_q      <= '0;
    end else begin
      if (wr_ctrl && priv) ctrl <= sreg_wdata[1:0];
      if (wr_mask)          mask_bit <= sreg_wdata[0];
      else if (irq_disable) mask_bit <= 1'b1;
      else if (irq_enable)  mask_bit <= 1'b0;
      if (exc_enter) begin
        in_handler <= 1'b1;
        exc_q      <= exc_num;
      end else if (exc_return) begin
        in_handler <= 1'b0;
        exc_q      <= '0;
      end
    end
  end

  always_comb begin
    case (sreg_sel)
      SEL_MAIN: sreg_rdata = main_sp;
      SEL_PROC: sreg_rdata = proc_sp;
      SEL_CTRL: sreg_rdata = {{(DW-2){1'b0}}, ctrl};
      default:  sreg_rdata = {{(DW-1){1'b0}}, mask_bit};
    endcase
  end

  assign sp_active    = cur_sp;
  assign privileged   = priv;
  assign irq_masked   = mask_bit;
  assign handler_mode = in_handler;
  assign exc_id       = exc_q;

  // R2: handler mode always runs on the main pointer
  a_r2_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_active == main_sp);

  // R4
  a_r4_unpriv_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_we && sreg_sel == SEL_CTRL && !privileged) |=> $stable(ctrl));

  // R4
  a_r4_handler_priv: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> privileged);

  // R5
  a_r5_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_disable && !(sreg_we && sreg_sel == SEL_MASK)) |=> irq_masked);

  // R6
  a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> handler_mode && exc_id == $past(exc_num));

  // R6
  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> !handler_mode && exc_id == '0);

  // R7
  a_r7_push: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && !sreg_we && !exc_enter && !exc_return)
      |=> sp_active == $past(sp_active) - {{PADW{1'b0}}, $past(stk_count), 2'b00});

  // R8
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    main_sp[1:0] == 2'b00 && proc_sp[1:0] == 2'b00);
endmodule

// File: tb/stack_mode_ctrl_test.sv
module stack_mode_ctrl_test;
  localparam int DW = 32, CNT_W = 4, EXC_W = 6;

  logic clk = 0, rst_n = 0;
  logic exc_enter = 0, exc_return = 0, sreg_we = 0;
  logic irq_disable = 0, irq_enable = 0, stk_push = 0, stk_pop = 0;
  logic [EXC_W-1:0] exc_num = '0;
  logic [1:0] sreg_sel = '0;
  logic [DW-1:0] sreg_wdata = '0;
  logic [CNT_W-1:0] stk_count = '0;
  logic [DW-1:0] sreg_rdata, sp_active;
  logic privileged, irq_masked, handler_mode;
  logic [EXC_W-1:0] exc_id;

  stack_mode_ctrl #(.DW(DW), .CNT_W(CNT_W), .EXC_W(EXC_W)) uut (
    .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_num(exc_num),
    .exc_return(exc_return), .sreg_we(sreg_we), .sreg_sel(sreg_sel),
    .sreg_wdata(sreg_wdata), .sreg_rdata(sreg_rdata), .irq_disable(irq_disable),
    .irq_enable(irq_enable), .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_count(stk_count), .sp_active(sp_active), .privileged(privileged),
    .irq_masked(irq_masked), .handler_mode(handler_mode), .exc_id(exc_id));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic done = 0;

  logic [DW-1:0] m_main = 0, m_proc = 0;
  logic [1:0] m_ctrl = 0;
  logic m_mask = 0, m_hand = 0;
  logic [EXC_W-1:0] m_exc = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_useproc();
    return !m_hand && m_ctrl[1];
  endfunction

  function automatic logic [DW-1:0] m_sp();
    return m_useproc() ? m_proc : m_main;
  endfunction

  function automatic logic m_priv();
    return m_hand || !m_ctrl[0];
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_main;
      2'd1: return m_proc;
      2'd2: return {30'b0, m_ctrl};
      default: return {31'b0, m_mask};
    endcase
  endfunction

  // reference update from the requirement rules, using state before the edge
  task automatic model_edge();
    logic [DW-1:0] d, nsp, w;
    logic up;
    up = m_useproc();
    d = {26'b0, stk_count, 2'b00};
    nsp = stk_push ? m_sp() - d : m_sp() + d;
    w = {sreg_wdata[DW-1:2], 2'b00};
    if (sreg_we && sreg_sel == 2'd0) m_main = w;
    else if ((stk_push || stk_pop) && !up) m_main = nsp;
    if (sreg_we && sreg_sel == 2'd1) m_proc = w;
    else if ((stk_push || stk_pop) && up) m_proc = nsp;
    if (sreg_we && sreg_sel == 2'd2 && m_priv()) m_ctrl = sreg_wdata[1:0];
    if (sreg_we && sreg_sel == 2'd3) m_mask = sreg_wdata[0];
    else if (irq_disable) m_mask = 1;
    else if (irq_enable) m_mask = 0;
    if (exc_enter) begin m_hand = 1; m_exc = exc_num; end
    else if (exc_return) begin m_hand = 0; m_exc = 0; end
  endtask

  task automatic idle();
    exc_enter = 0; exc_return = 0; sreg_we = 0; irq_disable = 0;
    irq_enable = 0; stk_push = 0; stk_pop = 0;
  endtask

  task automatic compare_all();
    check("R2/R3/R7 sp_active", sp_active, m_sp());
    check("R4 privileged", {31'b0, privileged}, {31'b0, m_priv()});
    check("R5 irq_masked", {31'b0, irq_masked}, {31'b0, m_mask});
    check("R6 handler_mode", {31'b0, handler_mode}, {31'b0, m_hand});
    check("R6 exc_id", {26'b0, exc_id}, {26'b0, m_exc});
    check("R9 sreg_rdata", sreg_rdata, m_read(sreg_sel));
  endtask

  // apply currently driven inputs for one edge, then compare at the negedge
  task automatic cycle();
    #1 check("R9 sreg_rdata pre", sreg_rdata, m_read(sreg_sel));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] v);
    idle(); sreg_we = 1; sreg_sel = s; sreg_wdata = v; cycle(); idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sp_active", sp_active, 0);
    check("R1 handler_mode", {31'b0, handler_mode}, 0);
    check("R1 privileged", {31'b0, privileged}, 1);
    check("R1 irq_masked", {31'b0, irq_masked}, 0);
    check("R1 exc_id", {26'b0, exc_id}, 0);

    // R8 alignment on write
    wr(2'd0, 32'h2000_1007);
    check("R8 main aligned", sp_active, 32'h2000_1004);
    wr(2'd1, 32'h1000_00FF);
    // R3 thread select via control bit 1
    wr(2'd2, 32'h2);
    check("R3 process active", sp_active, 32'h1000_00FC);
    // R7 push of 3 on process pointer
    idle(); stk_push = 1; stk_count = 3; cycle(); idle();
    check("R7 push 3", sp_active, 32'h1000_00F0);
    sreg_sel = 2'd0; #1 check("R7 main untouched", sreg_rdata, 32'h2000_1004);
    // R2 supervisor call entry forces main
    idle(); exc_enter = 1; exc_num = 6'd11; cycle(); idle();
    check("R2 handler main", sp_active, 32'h2000_1004);
    check("R6 svc number", {26'b0, exc_id}, 32'd11);
    // R7 pop in handler on main, with both push and pop -> push wins
    idle(); stk_pop = 1; stk_count = 15; cycle(); idle();
    check("R7 pop 15", sp_active, 32'h2000_1040);
    idle(); stk_pop = 1; stk_push = 1; stk_count = 1; cycle(); idle();
    check("R7 push wins", sp_active, 32'h2000_103C);
    // R6 return clears
    idle(); exc_return = 1; cycle(); idle();
    check("R6 return exc_id", {26'b0, exc_id}, 0);
    check("R6 back to process", sp_active, 32'h1000_00F0);
    // R4 drop privilege, then control write is ignored
    wr(2'd2, 32'h3);
    check("R4 unprivileged", {31'b0, privileged}, 0);
    wr(2'd2, 32'h0);
    sreg_sel = 2'd2; #1 check("R4 ctrl write ignored", sreg_rdata, 32'h3);
    // R5 disable beats enable
    idle(); irq_disable = 1; irq_enable = 1; cycle(); idle();
    check("R5 disable wins", {31'b0, irq_masked}, 1);
    idle(); irq_enable = 1; cycle(); idle();
    check("R5 enable clears", {31'b0, irq_masked}, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      exc_enter   = ($urandom % 10) == 0;
      exc_return  = ($urandom % 8) == 0;
      exc_num     = EXC_W'($urandom);
      sreg_we     = ($urandom % 5) == 0;
      sreg_sel    = 2'($urandom);
      sreg_wdata  = $urandom;
      irq_disable = ($urandom % 6) == 0;
      irq_enable  = ($urandom % 6) == 0;
      stk_push    = ($urandom % 3) == 0;
      stk_pop     = ($urandom % 3) == 0;
      stk_count   = CNT_W'($urandom);
      cycle();
    end
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule